// File: doc/BRIEF.md
# Reset Source Capture Controller

This block collects reset requests from five places: an external reset pin, a watchdog overflow pulse, a clock-loss timeout pulse, a supply-monitor low condition (grouped with power-on), and a software request. It merges them into one stretched system reset and records which source caused the most recent reset. The watchdog counter, the clock-loss detector and the supply comparator are outside the block. They arrive here as input levels or pulses.

The block has two registers on a one-bit address. Address 0 reads and writes different logic. A read returns the latched cause flags. A write sets the clock-loss and supply-monitor source enables, and can fire a software reset. Address 1 holds the supply-monitor enable and shows a read-only supply-good status. The module's synchronous active-low reset `rst_n` acts as the power-on event.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst_o` is high. It stays high for 8 cycles after release. After this reset, address 0 reads 0x02 and address 1 reads 0x00, so the monitor enable, the clock-loss enable and the supply select are all cleared.
- R2: Every accepted reset event drives `sys_rst_o` high from the clock edge that samples it, for exactly 8 cycles. An event during an active stretch restarts the 8-cycle count.
- R3: Address 0 reads the cause flags in bits 4:0: bit 0 pin, bit 1 power/supply, bit 2 clock loss, bit 3 watchdog, bit 4 software. Bits 7:5 read 0. Each event sets only the winning source's bit and clears all the others.
- R4: When several sources request in the same cycle, the recorded cause follows this priority: power/supply, then pin, then clock loss, then watchdog, then software.
- R5: Writing address 0 with bit 4 set issues a software reset.
- R6: Writing address 0 bits 3 and 0 has no effect: no reset, and the flags do not change.
- R7: A clock-loss pulse causes a reset only while the enable written to address 0 bit 2 is 1. That enable survives pin, watchdog, clock-loss and software resets.
- R8: A supply reset needs both conditions: the monitor enable (address 1 bit 7) is 1, and the supply select (address 0 bit 1) is 1. With the monitor disabled, a low supply causes no reset.
- R9: Once the monitor is enabled and selected, a supply reset fires one cycle after the select is written if either of these holds: fewer than 16 cycles have passed since the monitor was enabled, or `supply_low_i` is high. Later, `supply_low_i` going high also fires a supply reset.
- R10: A power/supply reset clears the clock-loss enable and the supply select.
- R11: Address 1 bit 6 reads 1 only when the monitor is enabled, has been stable for 16 cycles, and `supply_low_i` is low.
- R12: Register writes are ignored while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pin_rst_i | input | 1 | External reset pin request |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| clk_loss_i | input | 1 | Clock-loss timeout pulse |
| supply_low_i | input | 1 | Supply comparator below threshold |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 cause/enable, 1 monitor control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| sys_rst_o | output | 1 | Stretched system reset |

## Verification
The hardest state to reach is a supply-monitor reset. It needs the monitor enable written at address 1 and then the select bit written at address 0. The outcome then depends on whether the 16-cycle settling window has passed. The stimulus first selects the source right after enabling the monitor, which gives an immediate reset. It then waits out the window, reselects the source, and raises the supply-low input in the same cycle as the pin request. This checks the priority and the clearing of the enables in one pass. Separate steps check that writes made during a stretch are dropped, and that the supply path stays silent when the monitor is disabled.

// File: rtl/rcc_pkg.sv
// Shared constants for the reset source capture controller.
// Assumes the cause bit positions double as write-enable positions.
package rcc_pkg;
    localparam int NSRC    = 5;
    localparam int IDX_PIN = 0;
    localparam int IDX_PWR = 1;
    localparam int IDX_CLK = 2;
    localparam int IDX_WDT = 3;
    localparam int IDX_SW  = 4;
    // Highest priority first
    localparam int PRIO_ORDER [NSRC] = '{IDX_PWR, IDX_PIN, IDX_CLK, IDX_WDT, IDX_SW};
endpackage

// File: rtl/rcc_cause_arb.sv
// Fixed-priority picker: turns the request vector into a one-hot grant.
// Assumes the order given by rcc_pkg::PRIO_ORDER (entry 0 wins).
module rcc_cause_arb
    import rcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic            any_req
);
    // Walk the order from lowest to highest so the highest request is written last.
    always_comb begin
        grant = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (req[PRIO_ORDER[k]]) begin
                grant = '0;
                grant[PRIO_ORDER[k]] = 1'b1;
            end
        end
    end

    assign any_req = |req;

    // R4
    prio_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[IDX_PWR] |-> grant[IDX_PWR]);
    // R4
    prio_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_PIN] && !req[IDX_PWR]) |-> grant[IDX_PIN]);
endmodule

// File: rtl/rcc_supply_mon.sv
// Supply-monitor model: counts settling cycles after enable and raises a
// reset event when the source is selected while unsettled or low.
// Assumes mon_en and sel are registered by the parent.
module rcc_supply_mon #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic sel,
    input  logic supply_low,
    output logic stable,
    output logic pwr_evt,
    output logic status_ok
);
    localparam int SCW = $clog2(STABLE_CYCLES + 1);

    logic [SCW-1:0] settle_q;

    // Settling counter: cleared while disabled, saturates at STABLE_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n || !mon_en)
            settle_q <= '0;
        else if (settle_q != SCW'(STABLE_CYCLES))
            settle_q <= settle_q + 1'b1;
    end

    assign stable    = (settle_q == SCW'(STABLE_CYCLES));
    assign pwr_evt   = mon_en && sel && (supply_low || !stable);
    assign status_ok = mon_en && stable && !supply_low;

    // R9
    settle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !stable);
    // R11
    status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !status_ok);
endmodule

// File: rtl/rcc_stretch.sv
// Reset stretcher: holds its output for LEN cycles after each load,
// reloading on every new load. Assumes LEN >= 1.
module rcc_stretch #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Down-counter: preset while in reset or on load, otherwise counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            cnt_q <= CW'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R2
    load_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);
    // R2
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset source capture controller top. Gathers five reset requests, stretches
// the winning one into sys_rst_o and latches its cause. Address 0 reads cause
// flags but writes enables and the software trigger; address 1 holds the
// supply-monitor enable and status. Assumes rst_n is the power-on event.
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int STRETCH_LEN   = 8,
    parameter int STABLE_CYCLES = 16,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_rst_i,
    input  logic          wdt_ovf_i,
    input  logic          clk_loss_i,
    input  logic          supply_low_i,
    input  logic          wr_en_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          sys_rst_o
);
    localparam int MON_EN_BIT = 7;
    localparam int MON_OK_BIT = 6;
    localparam logic [NSRC-1:0] PWR_ONLY = NSRC'(1) << IDX_PWR;

    logic [NSRC-1:0] cause_q;
    logic            clk_en_q;
    logic            sel_q;
    logic            mon_en_q;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            any_req;
    logic            pwr_evt;
    logic            stable;
    logic            status_ok;
    logic            wr_ok;
    logic            wr_cause;
    logic            wr_mon;
    logic            unused_wdata;

    // Writes are dropped while the system is held in reset.
    assign wr_ok        = wr_en_i && !sys_rst_o;
    assign wr_cause     = wr_ok && !addr_i;
    assign wr_mon       = wr_ok && addr_i;
    assign unused_wdata = ^wdata_i;

    // Gather the request vector from pins, gated sources and the software write.
    always_comb begin
        req          = '0;
        req[IDX_PIN] = pin_rst_i;
        req[IDX_PWR] = pwr_evt;
        req[IDX_CLK] = clk_loss_i && clk_en_q;
        req[IDX_WDT] = wdt_ovf_i;
        req[IDX_SW]  = wr_cause && wdata_i[IDX_SW];
    end

    rcc_cause_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .grant   (grant),
        .any_req (any_req)
    );

    rcc_supply_mon #(.STABLE_CYCLES(STABLE_CYCLES)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_en     (mon_en_q),
        .sel        (sel_q),
        .supply_low (supply_low_i),
        .stable     (stable),
        .pwr_evt    (pwr_evt),
        .status_ok  (status_ok)
    );

    rcc_stretch #(.LEN(STRETCH_LEN)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (any_req),
        .active (sys_rst_o)
    );

    // Cause flags: power-on at reset, otherwise the winner of each event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= PWR_ONLY;
        else if (any_req)
            cause_q <= grant;
    end

    // Source enables: cleared by any power-class reset, else loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n || grant[IDX_PWR]) begin
            clk_en_q <= 1'b0;
            sel_q    <= 1'b0;
        end else if (wr_cause) begin
            clk_en_q <= wdata_i[IDX_CLK];
            sel_q    <= wdata_i[IDX_PWR];
        end
    end

    // Monitor enable: only a hard power-on clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mon_en_q <= 1'b0;
        else if (wr_mon)
            mon_en_q <= wdata_i[MON_EN_BIT];
    end

    // Read mux: address selects the cause view or the monitor view.
    always_comb begin
        rdata_o = '0;
        if (!addr_i) begin
            rdata_o[NSRC-1:0] = cause_q;
        end else begin
            rdata_o[MON_EN_BIT] = mon_en_q;
            rdata_o[MON_OK_BIT] = status_ok;
        end
    end

    // R3
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cause_q));
    // R8
    mon_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_q |-> !pwr_evt);
    // R10
    pwr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[IDX_PWR] |=> (!clk_en_q && !sel_q));
    // R12
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_o && wr_en_i && !grant[IDX_PWR]) |=>
        ($stable(clk_en_q) && $stable(sel_q) && $stable(mon_en_q)));
    // R2
    evt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> sys_rst_o);
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst_i = 1'b0;
    logic       wdt_ovf_i = 1'b0;
    logic       clk_loss_i = 1'b0;
    logic       supply_low_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       addr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       sys_rst_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] en_bits = '0;

    // stimulus {sw,clk,wdt,pin}, expected cause flags
    localparam logic [8:0] VEC [8] = '{
        {4'b0001, 5'b00001},
        {4'b0010, 5'b01000},
        {4'b0100, 5'b00100},
        {4'b1000, 5'b10000},
        {4'b0011, 5'b00001},
        {4'b0110, 5'b00100},
        {4'b1010, 5'b01000},
        {4'b1111, 5'b00001}
    };

    always #2 clk = ~clk;

    rst_cause_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_rst_i    (pin_rst_i),
        .wdt_ovf_i    (wdt_ovf_i),
        .clk_loss_i   (clk_loss_i),
        .supply_low_i (supply_low_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .sys_rst_o    (sys_rst_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        tick();
        wr_en_i = 1'b0;
        wdata_i = '0;
    endtask

    // apply one-cycle request {sw,clk,wdt,pin}; returns just after the sampling edge
    task automatic fire(input logic [3:0] s);
        pin_rst_i  = s[0];
        wdt_ovf_i  = s[1];
        clk_loss_i = s[2];
        if (s[3]) begin
            wr_en_i = 1'b1;
            addr_i  = 1'b0;
            wdata_i = 8'h10 | en_bits;
        end
        tick();
        pin_rst_i  = 1'b0;
        wdt_ovf_i  = 1'b0;
        clk_loss_i = 1'b0;
        wr_en_i    = 1'b0;
        wdata_i    = '0;
    endtask

    // called just after the sampling edge: high for 8 cycles then low
    task automatic expect_pulse(input string tag);
        chk({tag, " start"}, {7'd0, sys_rst_o}, 8'd1);
        repeat (7) tick();
        chk({tag, " last"}, {7'd0, sys_rst_o}, 8'd1);
        tick();
        chk({tag, " end"}, {7'd0, sys_rst_o}, 8'd0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        // R1 reset held
        chk("R1 held", {7'd0, sys_rst_o}, 8'd1);
        rst_n = 1'b1;
        tick();
        repeat (6) tick();
        chk("R1 stretch last", {7'd0, sys_rst_o}, 8'd1);
        tick();
        chk("R1 stretch end", {7'd0, sys_rst_o}, 8'd0);
        rd(1'b0, v); chk("R1 cause", v, 8'h02);
        rd(1'b1, v); chk("R1 mon", v, 8'h00);

        // R7 clock loss ignored while disabled
        fire(4'b0100);
        chk("R7 disabled", {7'd0, sys_rst_o}, 8'd0);

        // R6 write of read-only bits
        wr(1'b0, 8'h09);
        chk("R6 no reset", {7'd0, sys_rst_o}, 8'd0);
        tick();
        rd(1'b0, v); chk("R6 flags", v, 8'h02);

        // table walk with clock-loss enabled
        en_bits = 8'h04;
        wr(1'b0, en_bits);
        tick();
        for (int i = 0; i < 8; i++) begin
            fire(VEC[i][8:5]);
            expect_pulse("R2");
            rd(1'b0, v);
            if ($countones(VEC[i][8:5]) > 1)
                chk("R4 prio", v, {3'd0, VEC[i][4:0]});
            else if (VEC[i][8])
                chk("R5 sw", v, {3'd0, VEC[i][4:0]});
            else
                chk("R3 cause", v, {3'd0, VEC[i][4:0]});
            tick();
        end

        // R7 enable survived non-power resets
        fire(4'b0100);
        expect_pulse("R7 kept");
        rd(1'b0, v); chk("R7 flags", v, 8'h04);

        // R9 select while unsettled
        wr(1'b1, 8'h80);
        en_bits = 8'h06;
        wr(1'b0, en_bits);
        tick();
        expect_pulse("R9 unsettled");
        rd(1'b0, v); chk("R9 flags", v, 8'h02);
        en_bits = 8'h00;
        // R10 clock-loss enable cleared
        fire(4'b0100);
        chk("R10 cleared", {7'd0, sys_rst_o}, 8'd0);

        // R11 status after settling
        repeat (20) tick();
        rd(1'b1, v); chk("R11 ok", v, 8'hC0);
        supply_low_i = 1'b1;
        rd(1'b1, v); chk("R11 low", v, 8'h80);
        supply_low_i = 1'b0;
        tick();

        // R8 settled and selected: no reset while supply good
        wr(1'b0, 8'h02);
        repeat (2) tick();
        chk("R8 no reset", {7'd0, sys_rst_o}, 8'd0);

        // R4 supply low and pin in the same cycle
        supply_low_i = 1'b1;
        pin_rst_i    = 1'b1;
        tick();
        supply_low_i = 1'b0;
        pin_rst_i    = 1'b0;
        expect_pulse("R9 low");
        rd(1'b0, v); chk("R4 pwr over pin", v, 8'h02);

        // R12 write during stretch dropped
        fire(4'b0010);
        wr(1'b0, 8'h04);
        repeat (10) tick();
        fire(4'b0100);
        chk("R12 dropped", {7'd0, sys_rst_o}, 8'd0);
        rd(1'b0, v); chk("R12 flags", v, 8'h08);

        // R8 monitor disabled
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h02);
        supply_low_i = 1'b1;
        repeat (3) tick();
        chk("R8 disabled", {7'd0, sys_rst_o}, 8'd0);
        rd(1'b1, v); chk("R11 disabled", v, 8'h00);
        supply_low_i = 1'b0;
        tick();

        // R1 power-on clears monitor enable
        wr(1'b1, 8'h80);
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (10) tick();
        rd(1'b1, v); chk("R1 mon cleared", v, 8'h00);
        rd(1'b0, v); chk("R1 cause again", v, 8'h02);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule